// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of address translations. Each entry holds a virtual page number, a physical frame number, a valid flag and the address space identifier of the process that owns the mapping. A single current-identifier register, written by software on a context switch, selects which process's entries may hit. Entries from many processes therefore live side by side, and a context switch needs no invalidation.

A lookup presents a virtual address. The block compares its page number and the current identifier against every entry at once. One clock edge later it returns a hit flag and the physical address: the cached frame number placed above the untouched page offset.

After a miss, the walker outside the block installs the mapping with a fill request. The fill is tagged with the current identifier. Invalidation is done either for one identifier or for the whole table. Either form takes a single cycle, which lets the system reuse identifiers.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so the first lookups miss.
- R2: A lookup hits only when an entry is valid, its page number equals the requested page number and its stored identifier equals the current identifier. The same page number may be held under several identifiers at once, each with its own frame.
- R3: Writing the identifier register invalidates no entry. A lookup or fill in the same cycle as the write still uses the old identifier, and the new value applies from the next cycle.
- R4: On a hit, `rsp_paddr` is the frame number in bits [PFN_W+OFF_W-1:OFF_W] with the offset (the low OFF_W bits of `lk_vaddr`) unchanged in bits [OFF_W-1:0]. On a miss, `rsp_paddr` is zero.
- R5: A lookup sampled at a rising edge gives `rsp_valid`, `rsp_hit` and `rsp_paddr` after that same edge. `rsp_valid` is low after any edge at which `lk_valid` was low.
- R6: A fill installs its page and frame under the current identifier, and a lookup in the next cycle finds it.
- R7: A fill whose page number and current identifier are already held overwrites that entry's frame. It creates no second entry and displaces no other entry.
- R8: A fill that matches no entry goes to the lowest-numbered invalid entry when any entry is invalid. It leaves all valid entries intact.
- R9: When every entry is valid, a non-matching fill replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such replacements.
- R10: A flush by identifier invalidates, in one cycle, every entry tagged with that identifier and no other entry.
- R11: A global flush invalidates every entry in one cycle. A global flush takes priority over a flush by identifier, which takes priority over a fill; a fill in a flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| asid_wr_en | input | 1 | Write the current-identifier register |
| asid_wr_data | input | ASID_W | New current identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| fill_en | input | 1 | Install a mapping under the current identifier |
| fill_vpn | input | VPN_W | Page number of the mapping |
| fill_pfn | input | PFN_W | Frame number of the mapping |
| flush_id_en | input | 1 | Invalidate all entries of one identifier |
| flush_id | input | ASID_W | Identifier to invalidate |
| flush_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present (one cycle after a lookup) |
| rsp_hit | output | 1 | Lookup found a mapping |
| rsp_paddr | output | PFN_W+OFF_W | Translated physical address, zero on miss |

## Verification
A lookup result is due after the rising edge that samples the request. An update from a fill, flush or identifier write is visible to a lookup presented in the following cycle. The bench changes every input on the falling edge and reads the response 1 ns after the next rising edge. It applies each update as its own cycle before the lookups that depend on it. The one exception is the same-cycle case of R3, where the identifier write and the lookup share an edge on purpose.

// File: rtl/tlb_pkg.sv
// Shared types for the ASID-tagged TLB.
// Assumes: used by every module of the block; no parameters live here.
package tlb_pkg;

    // Table update selected for one cycle, already prioritised.
    typedef enum logic [1:0] {
        OP_IDLE      = 2'd0,
        OP_FILL      = 2'd1,
        OP_FLUSH_ID  = 2'd2,
        OP_FLUSH_ALL = 2'd3
    } tlb_op_e;

endpackage

// File: rtl/tlb_entry_array.sv
// Storage and match logic for all entries of the TLB.
// Each entry compares itself against the lookup key and the fill key.
// Assumes: op is already prioritised; wr_idx is valid whenever op is OP_FILL.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 18,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  tlb_op_e                  op,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PFN_W-1:0]         fill_pfn,
    input  logic [ASID_W-1:0]        cur_asid,
    input  logic [ASID_W-1:0]        flush_id,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic [ENTRIES-1:0]       valid_o,
    output logic [ENTRIES-1:0]       lk_match_o,
    output logic [ENTRIES-1:0]       fill_match_o,
    output logic [ENTRIES*PFN_W-1:0] pfn_flat_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic              vld_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic              tag_ok;

        // Entry state: flushes clear the valid flag, a fill aimed here loads it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                vpn_q  <= '0;
                asid_q <= '0;
                pfn_q  <= '0;
            end else if (op == OP_FLUSH_ALL) begin
                vld_q <= 1'b0;
            end else if (op == OP_FLUSH_ID) begin
                if (asid_q == flush_id) vld_q <= 1'b0;
            end else if (op == OP_FILL && wr_idx == IDX_W'(g)) begin
                vld_q  <= 1'b1;
                vpn_q  <= fill_vpn;
                asid_q <= cur_asid;
                pfn_q  <= fill_pfn;
            end
        end

        // Match of this entry against both keys, which share the current identifier.
        always_comb begin
            tag_ok             = vld_q && (asid_q == cur_asid);
            lk_match_o[g]      = tag_ok && (vpn_q == lk_vpn);
            fill_match_o[g]    = tag_ok && (vpn_q == fill_vpn);
            valid_o[g]         = vld_q;
            pfn_flat_o[g*PFN_W +: PFN_W] = pfn_q;
        end
    end

endmodule

// File: rtl/tlb_victim_sel.sv
// Chooses the entry a fill writes: a matching entry, else the lowest invalid
// entry, else the round-robin pointer, which advances only on replacements.
// Assumes: fill_match has at most one bit set.
module tlb_victim_sel #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] fill_match,
    output logic [IDX_W-1:0]   wr_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;
    logic             replace;

    // Priority encoders: index of the matching entry and of the lowest free entry.
    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fill_match[i]) match_idx = IDX_W'(i);
            if (!valid[i])     free_idx  = IDX_W'(i);
        end
        any_match = |fill_match;
        any_free  = ~&valid;
        replace   = fill_go && !any_match && !any_free;
    end

    // Target selection in priority order.
    always_comb begin
        if (any_match)     wr_idx = match_idx;
        else if (any_free) wr_idx = free_idx;
        else               wr_idx = rr_q;
    end

    // Round-robin pointer, moved only when a valid entry is displaced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (replace) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_resp_stage.sv
// Selects the frame of the hitting entry and registers the response.
// Assumes: lk_match has at most one bit set, so an OR of masked frames is exact.
module tlb_resp_stage #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 18,
    parameter int OFF_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [ENTRIES-1:0]       lk_match,
    input  logic [ENTRIES*PFN_W-1:0] pfn_flat,
    input  logic [OFF_W-1:0]         lk_off,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [PFN_W+OFF_W-1:0]   rsp_paddr
);

    logic             hit_c;
    logic [PFN_W-1:0] pfn_c;

    // One-hot mux of the frame numbers.
    always_comb begin
        pfn_c = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            pfn_c = pfn_c | (pfn_flat[i*PFN_W +: PFN_W] & {PFN_W{lk_match[i]}});
        end
        hit_c = |lk_match;
    end

    // Output register: response one edge after the request, zero address on miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit_c;
            rsp_paddr <= (lk_valid && hit_c) ? {pfn_c, lk_off} : '0;
        end
    end

endmodule

// File: rtl/asid_tlb.sv
// Fully associative TLB with identifier-tagged entries and a current-identifier
// register. Lookups respond one cycle later; fills and flushes update in one cycle.
// Assumes: a page walker outside issues fills after misses; ENTRIES >= 2.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 18,
    parameter int ASID_W  = 8,
    parameter int OFF_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     asid_wr_en,
    input  logic [ASID_W-1:0]        asid_wr_data,
    input  logic                     lk_valid,
    input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
    input  logic                     fill_en,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PFN_W-1:0]         fill_pfn,
    input  logic                     flush_id_en,
    input  logic [ASID_W-1:0]        flush_id,
    input  logic                     flush_all,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [PFN_W+OFF_W-1:0]   rsp_paddr
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ASID_W-1:0]        cur_asid_q;
    tlb_op_e                  op;
    logic [IDX_W-1:0]         wr_idx;
    logic [ENTRIES-1:0]       entry_valid;
    logic [ENTRIES-1:0]       lk_match;
    logic [ENTRIES-1:0]       fill_match;
    logic [ENTRIES*PFN_W-1:0] pfn_flat;

    // Current-identifier register, written on a context switch.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_asid_q <= '0;
        else if (asid_wr_en) cur_asid_q <= asid_wr_data;
    end

    // Update priority: global flush, then flush by identifier, then fill.
    always_comb begin
        if (flush_all)        op = OP_FLUSH_ALL;
        else if (flush_id_en) op = OP_FLUSH_ID;
        else if (fill_en)     op = OP_FILL;
        else                  op = OP_IDLE;
    end

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W),
        .IDX_W   (IDX_W)
    ) i_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .wr_idx       (wr_idx),
        .fill_vpn     (fill_vpn),
        .fill_pfn     (fill_pfn),
        .cur_asid     (cur_asid_q),
        .flush_id     (flush_id),
        .lk_vpn       (lk_vaddr[VPN_W+OFF_W-1:OFF_W]),
        .valid_o      (entry_valid),
        .lk_match_o   (lk_match),
        .fill_match_o (fill_match),
        .pfn_flat_o   (pfn_flat)
    );

    tlb_victim_sel #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) i_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_go    (op == OP_FILL),
        .valid      (entry_valid),
        .fill_match (fill_match),
        .wr_idx     (wr_idx)
    );

    tlb_resp_stage #(
        .ENTRIES (ENTRIES),
        .PFN_W   (PFN_W),
        .OFF_W   (OFF_W)
    ) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_match  (lk_match),
        .pfn_flat  (pfn_flat),
        .lk_off    (lk_vaddr[OFF_W-1:0]),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/asid_tlb_chk.sv
// Property checker for asid_tlb, attached by bind below.
// Assumes: the bound top has signals entry_valid and lk_match.
module asid_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 18,
    parameter int OFF_W   = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [OFF_W-1:0]       lk_off,
    input logic                   flush_all,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic [PFN_W+OFF_W-1:0] rsp_paddr,
    input logic [ENTRIES-1:0]     valid_vec,
    input logic [ENTRIES-1:0]     lk_match
);

    // R5
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R5
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));

    // R4
    miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

    // R4
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_off)));

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R6
    one_new_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_vec) <= $countones($past(valid_vec)) + 1);

    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_all) && lk_valid) |=> !rsp_hit);

endmodule

bind asid_tlb asid_tlb_chk #(
    .ENTRIES (ENTRIES),
    .PFN_W   (PFN_W),
    .OFF_W   (OFF_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_off    (lk_vaddr[OFF_W-1:0]),
    .flush_all (flush_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .valid_vec (entry_valid),
    .lk_match  (lk_match)
);

// File: tb/test_asid_tlb.sv
// Self-checking bench for asid_tlb in its default configuration.
module test_asid_tlb;

    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 18;
    localparam int ASID_W  = 8;
    localparam int OFF_W   = 12;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   asid_wr_en;
    logic [ASID_W-1:0]      asid_wr_data;
    logic                   lk_valid;
    logic [VPN_W+OFF_W-1:0] lk_vaddr;
    logic                   fill_en;
    logic [VPN_W-1:0]       fill_vpn;
    logic [PFN_W-1:0]       fill_pfn;
    logic                   flush_id_en;
    logic [ASID_W-1:0]      flush_id;
    logic                   flush_all;
    logic                   rsp_valid;
    logic                   rsp_hit;
    logic [PFN_W+OFF_W-1:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    asid_tlb #(
        .ENTRIES (ENTRIES), .VPN_W (VPN_W), .PFN_W (PFN_W),
        .ASID_W (ASID_W), .OFF_W (OFF_W)
    ) i_asid_tlb (
        .clk (clk), .rst_n (rst_n),
        .asid_wr_en (asid_wr_en), .asid_wr_data (asid_wr_data),
        .lk_valid (lk_valid), .lk_vaddr (lk_vaddr),
        .fill_en (fill_en), .fill_vpn (fill_vpn), .fill_pfn (fill_pfn),
        .flush_id_en (flush_id_en), .flush_id (flush_id), .flush_all (flush_all),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_paddr (rsp_paddr)
    );

    // Watchdog: a hung run is one failed check and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Frame number the bench assigns to a (identifier, page) pair.
    function automatic logic [PFN_W-1:0] pfn_of(input int asid, input int vpn, input int gen);
        return PFN_W'(vpn * 37 + asid * 1000 + gen * 5003 + 7);
    endfunction

    // One lookup: drive at the falling edge, read 1 ns after the rising edge.
    task automatic look(input string req, input int vpn, input int off,
                        input bit exp_hit, input logic [PFN_W-1:0] exp_pfn);
        logic [PFN_W+OFF_W-1:0] exp_pa;
        exp_pa   = exp_hit ? {exp_pfn, OFF_W'(off)} : '0;
        lk_valid = 1'b1;
        lk_vaddr = {VPN_W'(vpn), OFF_W'(off)};
        @(posedge clk);
        #1;
        checks = checks + 1;
        if (rsp_valid !== 1'b1 || rsp_hit !== exp_hit || rsp_paddr !== exp_pa) begin
            errors = errors + 1;
            $display("FAIL %s vpn=%0d actual v=%b h=%b pa=%h expected v=1 h=%b pa=%h",
                     req, vpn, rsp_valid, rsp_hit, rsp_paddr, exp_hit, exp_pa);
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic set_asid(input int a);
        asid_wr_en = 1'b1;
        asid_wr_data = ASID_W'(a);
        @(negedge clk);
        asid_wr_en = 1'b0;
    endtask

    task automatic fill(input int vpn, input logic [PFN_W-1:0] pfn);
        fill_en = 1'b1;
        fill_vpn = VPN_W'(vpn);
        fill_pfn = pfn;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush_one(input int a);
        flush_id_en = 1'b1;
        flush_id = ASID_W'(a);
        @(negedge clk);
        flush_id_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        asid_wr_en = 0; asid_wr_data = '0; lk_valid = 0; lk_vaddr = '0;
        fill_en = 0; fill_vpn = '0; fill_pfn = '0;
        flush_id_en = 0; flush_id = '0; flush_all = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle response after reset, empty table
        checks = checks + 1;
        if (rsp_valid !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1 rsp_valid actual=%b expected=0", rsp_valid);
        end
        for (int v = 0; v < ENTRIES; v++) look("R1", v, 0, 0, '0);

        // R6 R4 R8: fill every entry under identifier 1 and read each back
        set_asid(1);
        for (int v = 0; v < ENTRIES; v++) fill(v, pfn_of(1, v, 0));
        for (int v = 0; v < ENTRIES; v++) look("R6", v, v * 291 + 1, 1, pfn_of(1, v, 0));
        look("R4", 5, 4095, 1, pfn_of(1, 5, 0));

        // R5: no response after an idle edge
        @(posedge clk); #1;
        checks = checks + 1;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R5 idle actual v=%b h=%b expected v=0 h=0", rsp_valid, rsp_hit);
        end
        @(negedge clk);

        // R2: other identifier misses
        set_asid(2);
        for (int v = 0; v < ENTRIES; v++) look("R2", v, 3, 0, '0);

        // R3: write and lookup in one cycle use the old identifier (2 -> 1)
        asid_wr_en = 1'b1; asid_wr_data = ASID_W'(1);
        look("R3 same-cycle", 4, 0, 0, '0);
        asid_wr_en = 1'b0;
        for (int v = 0; v < ENTRIES; v++) look("R3", v, 8, 1, pfn_of(1, v, 0));

        // R7: refill of an existing pair replaces the frame, evicts nothing
        fill(3, pfn_of(1, 3, 1));
        for (int v = 0; v < ENTRIES; v++)
            look("R7", v, 2, 1, (v == 3) ? pfn_of(1, 3, 1) : pfn_of(1, v, 0));

        // R9: full table, pointer starts at entry 0 then 1
        fill(100, pfn_of(1, 100, 0));
        look("R9", 0, 0, 0, '0);
        look("R9", 100, 0, 1, pfn_of(1, 100, 0));
        look("R9", 1, 0, 1, pfn_of(1, 1, 0));
        fill(101, pfn_of(1, 101, 0));
        look("R9", 1, 0, 0, '0);
        look("R9", 101, 0, 1, pfn_of(1, 101, 0));
        for (int v = 2; v < ENTRIES; v++)
            look("R9", v, 0, 1, (v == 3) ? pfn_of(1, 3, 1) : pfn_of(1, v, 0));

        // R11: global flush wins over a fill in the same cycle
        flush_all = 1'b1; fill_en = 1'b1; fill_vpn = VPN_W'(200); fill_pfn = pfn_of(1, 200, 0);
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        look("R11", 200, 0, 0, '0);
        look("R11", 100, 0, 0, '0);
        for (int v = 2; v < ENTRIES; v++) look("R11", v, 0, 0, '0);

        // R2: same pages under identifiers 1 and 2 with different frames
        for (int v = 0; v < 4; v++) fill(v, pfn_of(1, v, 2));
        set_asid(2);
        for (int v = 0; v < 4; v++) fill(v, pfn_of(2, v, 2));
        for (int v = 0; v < 4; v++) look("R2 coexist", v, 17, 1, pfn_of(2, v, 2));
        set_asid(1);
        for (int v = 0; v < 4; v++) look("R2 coexist", v, 17, 1, pfn_of(1, v, 2));

        // R10: flush identifier 1 only
        flush_one(1);
        for (int v = 0; v < 4; v++) look("R10", v, 0, 0, '0);

        // R8: four free entries absorb four fills without displacing identifier 2
        for (int v = 40; v < 44; v++) fill(v, pfn_of(1, v, 3));
        for (int v = 40; v < 44; v++) look("R8", v, 1, 1, pfn_of(1, v, 3));
        set_asid(2);
        for (int v = 0; v < 4; v++) look("R8 R10", v, 1, 1, pfn_of(2, v, 2));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule